// File: doc/BRIEF.md
# Cache Line Fill Buffer

This block gathers one instruction cache line of eight 32-bit words from a 64-bit read data bus. The core side asks for a line with a line address. The block raises a bus read request, holds it until the bus acknowledges the address, and then collects four doubleword beats. Each beat arrives with a 3-bit word address. The block places every beat by that address and never by arrival count, so a fill that starts mid-line and wraps (for example word 6, then 0, 2, 4) builds the same line as an in-order fill.

When all four doublewords are present, the block emits a one-cycle line-complete strobe. In that cycle the 256-bit line and its line address are valid for the cache write port, and the arrival mask clears for the next fill. The bus runs at half the core rate. A bus-cycle enable marks the core cycles in which bus-side inputs are sampled, and all other core cycles leave the bus handshake and the beat capture alone.

Top module: `line_fill_buffer`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, bus_req, fill_busy, line_valid and proto_err are all 0. Reset applied in the middle of a fill abandons that fill.
- R2: When fetch_req is high and fill_busy is low at a clock edge, the request is taken. From the next cycle, bus_req and fill_busy are 1 and line_addr equals the sampled fetch_addr.
- R3: bus_req stays high until a cycle in which bus_ce and addr_ack are both 1, and it is low from the following cycle. The acknowledge may come in the first bus cycle of the request.
- R4: addr_ack and rd_ack have no effect in cycles where bus_ce is 0. A beat that is held on the bus for both core cycles of a bus cycle is captured exactly once.
- R5: A beat with rd_wdaddr = 2s stores rd_data[31:0] as word 2s at line_data[64s+31:64s] and rd_data[63:32] as word 2s+1 at line_data[64s+63:64s+32].
- R6: Beats may arrive in any order, including orders that start mid-line and wrap. The completed line depends only on the word addresses.
- R7: line_valid is 1 for exactly one cycle, the cycle after the fourth distinct doubleword is captured, and never earlier. In that cycle, line_data holds the full line, line_addr holds the line address, and fill_busy is 0.
- R8: fetch_req is ignored while fill_busy is 1. line_addr and the fill in progress are unchanged.
- R9: A beat aimed at a doubleword already filled in the current fill sets proto_err. It does not overwrite the stored data and does not count toward completion. proto_err stays set until reset.
- R10: rd_ack while fill_busy is 0 is ignored. It stores nothing, sets no error and does not count toward the next fill.
- R11: A completed fill clears the arrival record. The next fill completes only after four new distinct beats.
- R12: A beat whose word address is odd sets proto_err and is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Bus-cycle enable; bus inputs count only when high |
| fetch_req | input | 1 | Core asks for a line fill |
| fetch_addr | input | 27 | Line address of the requested fill |
| addr_ack | input | 1 | Bus accepts the address phase |
| rd_ack | input | 1 | Read data beat valid on the bus |
| rd_wdaddr | input | 3 | Word address of the current beat |
| rd_data | input | 64 | Read data beat, two words |
| bus_req | output | 1 | Line read request to the bus |
| fill_busy | output | 1 | A fill is outstanding |
| line_addr | output | 27 | Line address on the request and at hand-off |
| line_valid | output | 1 | One-cycle line-complete strobe to the cache |
| line_data | output | 256 | Assembled line, word w at bits 32w+31:32w |
| proto_err | output | 1 | Sticky flag for duplicate or odd-address beats |

## Verification
A wrong arrival mask shows directly at the ports. A bit that is never set keeps fill_busy high after the fourth beat, with no strobe. A bit that is not cleared makes the next fill strobe one beat early or flag a false duplicate, and both of these show within one bus cycle of the beat concerned. Wrong slot decoding does not change the strobe timing, but it shows as misplaced words in line_data on the strobe cycle. A handshake that ignores the bus enable captures a held beat twice, which raises proto_err one core cycle later.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_ADDR = 2'd1,
    FILL_DATA = 2'd2
  } fill_state_e;
endpackage

// File: rtl/lfb_req_ctrl.sv
module lfb_req_ctrl
  import lfb_pkg::*;
#(
  parameter int LA_W = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_ce,
  input  logic            fetch_req,
  input  logic [LA_W-1:0] fetch_addr,
  input  logic            addr_ack,
  input  logic            fill_done,
  output logic            bus_req,
  output logic            fill_busy,
  output logic [LA_W-1:0] line_addr
);
  fill_state_e     state_q, state_d;
  logic [LA_W-1:0] addr_q, addr_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    unique case (state_q)
      FILL_IDLE: begin
        if (fetch_req) begin
          addr_d  = fetch_addr;
          state_d = FILL_ADDR;
        end
      end
      FILL_ADDR: begin
        if (fill_done)                state_d = FILL_IDLE;
        else if (bus_ce && addr_ack)  state_d = FILL_DATA;
      end
      FILL_DATA: begin
        if (fill_done) state_d = FILL_IDLE;
      end
      default: state_d = FILL_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign bus_req   = (state_q == FILL_ADDR);
  assign fill_busy = (state_q != FILL_IDLE);
  assign line_addr = addr_q;
endmodule

// File: rtl/lfb_tracker.sv
module lfb_tracker #(
  parameter int BEATS   = 4,
  parameter int WADDR_W = 3,
  parameter int SEL_LO  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_ce,
  input  logic               rd_ack,
  input  logic [WADDR_W-1:0] rd_wdaddr,
  input  logic               fill_busy,
  output logic [BEATS-1:0]   slot_wr,
  output logic               fill_done,
  output logic               line_valid,
  output logic               proto_err
);
  localparam int SLOT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BEATS-1:0]  mask_q, mask_d, mask_new, slot_oh;
  logic [SLOT_W-1:0] slot;
  logic              beat_hit, misaligned, dup, err_q, err_d, lv_q, lv_d;

  assign beat_hit = bus_ce && rd_ack && fill_busy;
  assign slot     = SLOT_W'(rd_wdaddr[WADDR_W-1:SEL_LO]);
  assign slot_oh  = BEATS'(1) << slot;

  // misaligned word address check only exists when a beat spans several words
  generate
    if (SEL_LO > 0) begin : g_align
      assign misaligned = |rd_wdaddr[SEL_LO-1:0];
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  // next-state logic
  always_comb begin
    dup       = beat_hit && !misaligned && |(mask_q & slot_oh);
    slot_wr   = (beat_hit && !misaligned && !dup) ? slot_oh : '0;
    mask_new  = mask_q | slot_wr;
    fill_done = (|slot_wr) && (&mask_new);
    mask_d    = fill_done ? '0 : mask_new;
    err_d     = err_q | dup | (beat_hit && misaligned);
    lv_d      = fill_done;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      err_q  <= 1'b0;
      lv_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      err_q  <= err_d;
      lv_q   <= lv_d;
    end
  end

  assign line_valid = lv_q;
  assign proto_err  = err_q;
endmodule

// File: rtl/lfb_slot_store.sv
module lfb_slot_store #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 64
) (
  input  logic                    clk,
  input  logic [BEATS-1:0]        slot_wr,
  input  logic [BEAT_W-1:0]       wr_data,
  output logic [BEATS*BEAT_W-1:0] line_data
);
  // one doubleword register per slot; data needs no reset, validity is tracked elsewhere
  generate
    for (genvar s = 0; s < BEATS; s++) begin : g_slot
      logic [BEAT_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (slot_wr[s]) slot_q <= wr_data;
      end
      assign line_data[s*BEAT_W +: BEAT_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/line_fill_buffer.sv
module line_fill_buffer #(
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_BEAT = 2,
  parameter int BEATS          = 4,
  parameter int LA_W           = 27,
  localparam int BEAT_W        = WORD_W * WORDS_PER_BEAT,
  localparam int LINE_WORDS    = WORDS_PER_BEAT * BEATS,
  localparam int LINE_W        = BEAT_W * BEATS,
  localparam int WADDR_W       = $clog2(LINE_WORDS),
  localparam int SEL_LO        = $clog2(WORDS_PER_BEAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_ce,
  input  logic               fetch_req,
  input  logic [LA_W-1:0]    fetch_addr,
  input  logic               addr_ack,
  input  logic               rd_ack,
  input  logic [WADDR_W-1:0] rd_wdaddr,
  input  logic [BEAT_W-1:0]  rd_data,
  output logic               bus_req,
  output logic               fill_busy,
  output logic [LA_W-1:0]    line_addr,
  output logic               line_valid,
  output logic [LINE_W-1:0]  line_data,
  output logic               proto_err
);
  logic [BEATS-1:0] slot_wr;
  logic             fill_done;

  lfb_req_ctrl #(.LA_W(LA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ce    (bus_ce),
    .fetch_req (fetch_req),
    .fetch_addr(fetch_addr),
    .addr_ack  (addr_ack),
    .fill_done (fill_done),
    .bus_req   (bus_req),
    .fill_busy (fill_busy),
    .line_addr (line_addr)
  );

  lfb_tracker #(.BEATS(BEATS), .WADDR_W(WADDR_W), .SEL_LO(SEL_LO)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ce    (bus_ce),
    .rd_ack    (rd_ack),
    .rd_wdaddr (rd_wdaddr),
    .fill_busy (fill_busy),
    .slot_wr   (slot_wr),
    .fill_done (fill_done),
    .line_valid(line_valid),
    .proto_err (proto_err)
  );

  lfb_slot_store #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_store (
    .clk      (clk),
    .slot_wr  (slot_wr),
    .wr_data  (rd_data),
    .line_data(line_data)
  );
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
  parameter int LA_W = 27
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_ce,
  input logic            fetch_req,
  input logic            addr_ack,
  input logic            rd_ack,
  input logic            bus_req,
  input logic            fill_busy,
  input logic [LA_W-1:0] line_addr,
  input logic            line_valid,
  input logic            proto_err
);
  p_req_inside_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> fill_busy);

  p_req_drop_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ce && addr_ack) |=> !bus_req);

  p_req_hold_no_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ce) |=> bus_req);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !line_valid);

  p_strobe_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> !fill_busy);

  p_busy_keeps_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && !(bus_ce && rd_ack)) |=> (fill_busy && $stable(line_addr)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_busy && !fetch_req) |=> (!fill_busy && !line_valid));
endmodule

bind line_fill_buffer lfb_checker #(.LA_W(LA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ce    (bus_ce),
  .fetch_req (fetch_req),
  .addr_ack  (addr_ack),
  .rd_ack    (rd_ack),
  .bus_req   (bus_req),
  .fill_busy (fill_busy),
  .line_addr (line_addr),
  .line_valid(line_valid),
  .proto_err (proto_err)
);

// File: tb/line_fill_buffer_tb.sv
module line_fill_buffer_tb;
  logic         clk;
  logic         rst_n;
  logic         bus_ce, fetch_req, addr_ack, rd_ack;
  logic [26:0]  fetch_addr;
  logic [2:0]   rd_wdaddr;
  logic [63:0]  rd_data;
  logic         bus_req, fill_busy, line_valid, proto_err;
  logic [26:0]  line_addr;
  logic [255:0] line_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // samples from the last bus cycle: first core cycle (enable high) and second
  logic         lv1, lv2, busy1, req1;
  logic [255:0] ld1;
  logic [26:0]  la1;

  line_fill_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .addr_ack(addr_ack), .rd_ack(rd_ack),
    .rd_wdaddr(rd_wdaddr), .rd_data(rd_data), .bus_req(bus_req),
    .fill_busy(fill_busy), .line_addr(line_addr), .line_valid(line_valid),
    .line_data(line_data), .proto_err(proto_err)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // stimulus table: line address, beat order (slot of beat k at bits 2k+1:2k), ack wait
  localparam logic [26:0] V_ADDR  [4] = '{27'h0000010, 27'h7FFFFFF, 27'h1234567, 27'h2AAAAAA};
  localparam logic [7:0]  V_ORDER [4] = '{8'b11100100, 8'b10010011, 8'b01001110, 8'b00011011};
  localparam int          V_WAIT  [4] = '{0, 2, 0, 1};

  function automatic logic [31:0] exp_word(int tag, int w);
    return (32'(tag) << 8) | 32'(w);
  endfunction

  function automatic logic [63:0] exp_beat(int tag, int s);
    return {exp_word(tag, 2*s+1), exp_word(tag, 2*s)};
  endfunction

  function automatic logic [255:0] exp_line(int tag);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[32*w +: 32] = exp_word(tag, w);
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    bus_ce = 0; fetch_req = 0; addr_ack = 0; rd_ack = 0;
    fetch_addr = '0; rd_wdaddr = '0; rd_data = '0;
  endtask

  task automatic start_fetch(input logic [26:0] a);
    fetch_req = 1; fetch_addr = a;
    tick();
    fetch_req = 0;
  endtask

  // one bus cycle = two core cycles; bus signals held for both, enable only in the first
  task automatic bus_cycle(input logic aa, input logic da, input logic [2:0] wa, input logic [63:0] d);
    addr_ack = aa; rd_ack = da; rd_wdaddr = wa; rd_data = d;
    bus_ce = 1;
    tick();
    lv1 = line_valid; ld1 = line_data; la1 = line_addr; busy1 = fill_busy; req1 = bus_req;
    bus_ce = 0;
    tick();
    lv2 = line_valid;
    addr_ack = 0; rd_ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 0;
    repeat (3) tick();
    check("R1 bus_req in reset", 256'(bus_req), 256'(0));
    rst_n = 1;
    tick();
    check("R1 bus_req after reset", 256'(bus_req), 256'(0));
    check("R1 fill_busy after reset", 256'(fill_busy), 256'(0));
    check("R1 line_valid after reset", 256'(line_valid), 256'(0));
    check("R1 proto_err after reset", 256'(proto_err), 256'(0));

    // table-driven fills (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < 4; i++) begin
      start_fetch(V_ADDR[i]);
      check("R2 bus_req raised", 256'(bus_req), 256'(1));
      check("R2 fill_busy raised", 256'(fill_busy), 256'(1));
      check("R2 line_addr", 256'(line_addr), 256'(V_ADDR[i]));
      for (int w = 0; w < V_WAIT[i]; w++) begin
        bus_cycle(0, 0, 3'd0, '0);
        check("R3 bus_req held without ack", 256'(req1), 256'(1));
      end
      bus_cycle(1, 0, 3'd0, '0);
      check("R3 bus_req dropped after ack", 256'(req1), 256'(0));
      check("R4 bus_req stays low", 256'(bus_req), 256'(0));
      for (int k = 0; k < 4; k++) begin
        int s;
        s = int'(V_ORDER[i][2*k +: 2]);
        bus_cycle(0, 1, 3'(2*s), exp_beat(i + 1, s));
        if (k < 3) begin
          check("R7 no early strobe", 256'(lv1), 256'(0));
        end else begin
          check("R7 strobe on completion", 256'(lv1), 256'(1));
          check("R5 R6 line content", ld1, exp_line(i + 1));
          check("R7 line_addr at hand-off", 256'(la1), 256'(V_ADDR[i]));
          check("R7 fill_busy low at strobe", 256'(busy1), 256'(0));
          check("R7 strobe lasts one cycle", 256'(lv2), 256'(0));
        end
      end
      check("R4 held beat captured once", 256'(proto_err), 256'(0));
    end

    // R8: request while busy is refused
    start_fetch(27'h0ABCDEF);
    fetch_req = 1; fetch_addr = 27'h0111111;
    tick();
    fetch_req = 0;
    check("R8 line_addr kept while busy", 256'(line_addr), 256'(27'h0ABCDEF));
    check("R8 request still pending", 256'(bus_req), 256'(1));
    bus_cycle(1, 0, 3'd0, '0);
    for (int s = 0; s < 4; s++) bus_cycle(0, 1, 3'(2*s), exp_beat(20, s));
    check("R8 completed line address", 256'(la1), 256'(27'h0ABCDEF));
    check("R8 completed line content", ld1, exp_line(20));

    // R10: beat while idle ignored; R11: next fill needs four new beats
    bus_cycle(0, 1, 3'd0, exp_beat(99, 0));
    check("R10 idle beat no strobe", 256'(lv1), 256'(0));
    check("R10 idle beat no error", 256'(proto_err), 256'(0));
    start_fetch(27'h0000042);
    bus_cycle(1, 0, 3'd0, '0);
    for (int s = 1; s < 4; s++) begin
      bus_cycle(0, 1, 3'(2*s), exp_beat(21, s));
      check("R11 no strobe before four new beats", 256'(lv1), 256'(0));
    end
    check("R11 still busy after three beats", 256'(fill_busy), 256'(1));
    bus_cycle(0, 1, 3'd0, exp_beat(21, 0));
    check("R11 strobe after fourth beat", 256'(lv1), 256'(1));
    check("R10 R11 fresh line content", ld1, exp_line(21));

    // R9: duplicate beat flagged, not stored, not counted
    start_fetch(27'h0000077);
    bus_cycle(1, 0, 3'd0, '0);
    bus_cycle(0, 1, 3'd4, exp_beat(7, 2));
    check("R9 no error before duplicate", 256'(proto_err), 256'(0));
    bus_cycle(0, 1, 3'd4, exp_beat(9, 2));
    check("R9 duplicate flagged", 256'(proto_err), 256'(1));
    bus_cycle(0, 1, 3'd0, exp_beat(7, 0));
    bus_cycle(0, 1, 3'd2, exp_beat(7, 1));
    check("R9 duplicate not counted", 256'(lv1), 256'(0));
    bus_cycle(0, 1, 3'd6, exp_beat(7, 3));
    check("R9 strobe after real fourth beat", 256'(lv1), 256'(1));
    check("R9 duplicate did not overwrite", ld1, exp_line(7));
    check("R9 error stays set", 256'(proto_err), 256'(1));

    // R1: reset mid-fill abandons the fill and clears the error
    start_fetch(27'h0000100);
    bus_cycle(1, 0, 3'd0, '0);
    bus_cycle(0, 1, 3'd0, exp_beat(30, 0));
    rst_n = 0;
    tick();
    check("R1 mid-fill reset busy", 256'(fill_busy), 256'(0));
    check("R1 mid-fill reset error", 256'(proto_err), 256'(0));
    rst_n = 1;
    tick();

    // R12: odd word address flagged and discarded
    start_fetch(27'h0000200);
    bus_cycle(1, 0, 3'd0, '0);
    bus_cycle(0, 1, 3'd3, exp_beat(11, 1));
    check("R12 odd address flagged", 256'(proto_err), 256'(1));
    check("R12 fill still busy", 256'(fill_busy), 256'(1));
    for (int s = 3; s >= 0; s--) bus_cycle(0, 1, 3'(2*s), exp_beat(12, s));
    check("R12 strobe after four good beats", 256'(lv1), 256'(1));
    check("R12 odd beat not stored", ld1, exp_line(12));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule